// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block holds the hazard control for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory and writeback. It watches the register specifiers, write enables and load flags held in the pipeline latches. From them it produces the execute-stage operand bypass selects, a one-cycle freeze for the load-use case, and the squash strobes for a taken branch. The datapath muxes, the register file, the ALU and the memories sit outside the block and act on these strobes.

An ALU result is bypassed from the execute/memory latch to the next instruction, so no stall is needed. A load feeding the instruction right behind it costs one bubble. After that bubble the loaded value comes from the memory/writeback latch. Branches resolve in execute under predict-not-taken. A taken branch squashes the two younger instructions behind it and redirects fetch. A not-taken branch costs nothing. Reads happen in decode and writes happen in writeback, both in program order, so the block has no logic for write-after-read or write-after-write hazards. Two running counters report the bubble cycles and the squash-penalty cycles.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the execute/memory latch writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10 in the same cycle. No stall is raised.
- R2: When only the memory/writeback latch writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01. With no match the select is 2'b00, meaning register file.
- R3: When both latches write the same nonzero source register, the select is 2'b10. The younger result wins.
- R4: Register 0 is never bypassed: its select stays 2'b00 whatever the latches hold. A load into register 0 never stalls.
- R5: A load in the decode/execute latch whose nonzero destination matches a decode source that is in use raises pc_hold, ifid_hold and idex_bubble together. This happens only in that cycle, which gives exactly one bubble. After the bubble the consumer takes the value through select 2'b01.
- R6: No stall is raised for a non-load producer in the decode/execute latch, or for a decode source flagged as unused.
- R7: branch_taken raises pc_redirect, ifid_flush and idex_flush in the same cycle, which squashes two slots. With branch_taken low, none of the three is raised.
- R8: When a taken branch and a load-use match occur together, the flush wins and all stall outputs stay low.
- R9: stall_cnt rises by 1 after each stall cycle. flush_cnt rises by 2 after each taken-branch cycle. Neither changes otherwise.
- R10: A synchronous active-high reset clears both counters to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | AW | First source of the instruction in decode |
| id_rs1_used | input | 1 | First decode source is actually read |
| id_rs2 | input | AW | Second source of the instruction in decode |
| id_rs2_used | input | 1 | Second decode source is actually read |
| idex_rs1 | input | AW | First source of the instruction in execute |
| idex_rs2 | input | AW | Second source of the instruction in execute |
| idex_rd | input | AW | Destination held in the decode/execute latch |
| idex_is_load | input | 1 | Decode/execute latch holds a load |
| exmem_rd | input | AW | Destination held in the execute/memory latch |
| exmem_we | input | 1 | Execute/memory latch writes a register |
| memwb_rd | input | AW | Destination held in the memory/writeback latch |
| memwb_we | input | 1 | Memory/writeback latch writes a register |
| branch_taken | input | 1 | Branch in execute resolved taken |
| fwd_a_sel | output | 2 | First operand source: 00 file, 01 mem/wb, 10 ex/mem |
| fwd_b_sel | output | 2 | Second operand source, same encoding |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode latch |
| idex_bubble | output | 1 | Load a no-op into the decode/execute latch |
| pc_redirect | output | 1 | Steer fetch to the branch target |
| ifid_flush | output | 1 | Squash the fetch/decode latch |
| idex_flush | output | 1 | Squash the decode/execute latch |
| stall_cnt | output | CNT_W | Total bubble cycles inserted |
| flush_cnt | output | CNT_W | Total squash-penalty cycles |

## Verification
The bench targets the corner where both bypass latches hold the same register. A design with the priority reversed would feed the consumer a stale older value. It also drives register 0 as a destination. A careless compare there would bypass a value that must read as zero, or would stall on a load into zero. The load-use sequence is stepped cycle by cycle: the stall cycle, the bubble cycle, then the consumer in execute. This catches a design that stalls twice, or that bypasses from the wrong latch afterwards. The bench also makes a taken branch and a load-use match coincide. A design that let the stall win would freeze a wrong-path instruction and miscount the penalty.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned SQUASH_SLOTS = 2;
  localparam int unsigned NUM_SRC      = 2;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exmem_rd,
  input  logic          exmem_we,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_we,
  output fwd_sel_e      sel
);
  logic src_nz, hit_exmem, hit_memwb;

  always_comb begin
    src_nz    = (src != '0);
    hit_exmem = src_nz && exmem_we && (exmem_rd == src);
    hit_memwb = src_nz && memwb_we && (memwb_rd == src);
    if (hit_exmem)      sel = FWD_EXMEM;
    else if (hit_memwb) sel = FWD_MEMWB;
    else                sel = FWD_RF;
  end
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic          id_rs1_used,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs2_used,
  input  logic [AW-1:0] idex_rd,
  input  logic          idex_is_load,
  output logic          hit
);
  logic dest_live, m1, m2;

  always_comb begin
    dest_live = idex_is_load && (idex_rd != '0);
    m1        = id_rs1_used && (id_rs1 == idex_rd);
    m2        = id_rs2_used && (id_rs2 == idex_rd);
    hit       = dest_live && (m1 || m2);
  end
endmodule

// File: rtl/hz_ctrl_seq.sv
module hz_ctrl_seq
  import hz_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_req,
  input  logic             branch_taken,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             pc_redirect,
  output logic             ifid_flush,
  output logic             idex_flush,
  output logic [CNT_W-1:0] stall_cnt,
  output logic [CNT_W-1:0] flush_cnt
);
  localparam logic [CNT_W-1:0] PENALTY = CNT_W'(SQUASH_SLOTS);

  logic stall_eff;

  always_comb begin
    // a taken branch discards the instruction that would have stalled
    stall_eff   = stall_req && !branch_taken;
    pc_hold     = stall_eff;
    ifid_hold   = stall_eff;
    idex_bubble = stall_eff;
    pc_redirect = branch_taken;
    ifid_flush  = branch_taken;
    idex_flush  = branch_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_cnt <= '0;
      flush_cnt <= '0;
    end else begin
      if (stall_eff)    stall_cnt <= stall_cnt + 1'b1;
      if (branch_taken) flush_cnt <= flush_cnt + PENALTY;
    end
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hz_pkg::*;
#(
  parameter int unsigned AW    = 5,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    id_rs1,
  input  logic             id_rs1_used,
  input  logic [AW-1:0]    id_rs2,
  input  logic             id_rs2_used,
  input  logic [AW-1:0]    idex_rs1,
  input  logic [AW-1:0]    idex_rs2,
  input  logic [AW-1:0]    idex_rd,
  input  logic             idex_is_load,
  input  logic [AW-1:0]    exmem_rd,
  input  logic             exmem_we,
  input  logic [AW-1:0]    memwb_rd,
  input  logic             memwb_we,
  input  logic             branch_taken,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             pc_redirect,
  output logic             ifid_flush,
  output logic             idex_flush,
  output logic [CNT_W-1:0] stall_cnt,
  output logic [CNT_W-1:0] flush_cnt
);
  logic [AW-1:0] ex_src [NUM_SRC];
  fwd_sel_e      ex_sel [NUM_SRC];
  logic          lu_hit;

  assign ex_src[0] = idex_rs1;
  assign ex_src[1] = idex_rs2;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
    hz_fwd_unit #(.AW(AW)) fwd_i (
      .src      (ex_src[g]),
      .exmem_rd (exmem_rd),
      .exmem_we (exmem_we),
      .memwb_rd (memwb_rd),
      .memwb_we (memwb_we),
      .sel      (ex_sel[g])
    );
  end

  assign fwd_a_sel = ex_sel[0];
  assign fwd_b_sel = ex_sel[1];

  hz_loaduse_det #(.AW(AW)) lu_i (
    .id_rs1       (id_rs1),
    .id_rs1_used  (id_rs1_used),
    .id_rs2       (id_rs2),
    .id_rs2_used  (id_rs2_used),
    .idex_rd      (idex_rd),
    .idex_is_load (idex_is_load),
    .hit          (lu_hit)
  );

  hz_ctrl_seq #(.CNT_W(CNT_W)) seq_i (
    .clk          (clk),
    .rst          (rst),
    .stall_req    (lu_hit),
    .branch_taken (branch_taken),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .idex_bubble  (idex_bubble),
    .pc_redirect  (pc_redirect),
    .ifid_flush   (ifid_flush),
    .idex_flush   (idex_flush),
    .stall_cnt    (stall_cnt),
    .flush_cnt    (flush_cnt)
  );
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int unsigned AW    = 5,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    id_rs1,
  input logic             id_rs1_used,
  input logic [AW-1:0]    id_rs2,
  input logic             id_rs2_used,
  input logic [AW-1:0]    idex_rs1,
  input logic [AW-1:0]    idex_rs2,
  input logic [AW-1:0]    idex_rd,
  input logic             idex_is_load,
  input logic [AW-1:0]    exmem_rd,
  input logic             exmem_we,
  input logic [AW-1:0]    memwb_rd,
  input logic             memwb_we,
  input logic             branch_taken,
  input logic [1:0]       fwd_a_sel,
  input logic [1:0]       fwd_b_sel,
  input logic             pc_hold,
  input logic             ifid_hold,
  input logic             idex_bubble,
  input logic             pc_redirect,
  input logic             ifid_flush,
  input logic             idex_flush,
  input logic [CNT_W-1:0] stall_cnt,
  input logic [CNT_W-1:0] flush_cnt
);
  // R4
  zero_src_a_chk: assert property (@(posedge clk) disable iff (rst)
    (idex_rs1 == '0) |-> (fwd_a_sel == 2'b00));

  // R3
  younger_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (exmem_we && memwb_we && exmem_rd == memwb_rd && exmem_rd == idex_rs2
     && idex_rs2 != '0) |-> (fwd_b_sel == 2'b10));

  // R5
  stall_trio_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));

  // R8
  flush_over_stall_chk: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> (!pc_hold && !idex_bubble && ifid_flush && idex_flush));

  // R7
  no_spurious_flush_chk: assert property (@(posedge clk) disable iff (rst)
    !branch_taken |-> (!ifid_flush && !idex_flush && !pc_redirect));

  // R9
  stall_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    pc_hold |=> (stall_cnt == $past(stall_cnt) + 1'b1));

  // R9
  stall_count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_hold |=> $stable(stall_cnt));
endmodule

bind pipe_hazard_ctl hz_checker #(.AW(AW), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/pipe_hazard_ctl_tb_top.sv
module pipe_hazard_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] id_rs1, id_rs2, idex_rs1, idex_rs2, idex_rd, exmem_rd, memwb_rd;
  logic id_rs1_used, id_rs2_used, idex_is_load, exmem_we, memwb_we, branch_taken;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic pc_hold, ifid_hold, idex_bubble, pc_redirect, ifid_flush, idex_flush;
  logic [CNT_W-1:0] stall_cnt, flush_cnt;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_hazard_ctl #(.AW(AW), .CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs1 = '0; id_rs2 = '0; id_rs1_used = 0; id_rs2_used = 0;
    idex_rs1 = '0; idex_rs2 = '0; idex_rd = '0; idex_is_load = 0;
    exmem_rd = '0; exmem_we = 0; memwb_rd = '0; memwb_we = 0;
    branch_taken = 0;
  endtask

  task automatic next();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    rst = 1; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R10 stall_cnt", stall_cnt, 0);
    chk("R10 flush_cnt", flush_cnt, 0);
    chk("R2 idle sel a", fwd_a_sel, 0);
    chk("R6 idle hold", pc_hold, 0);
  endtask

  task automatic t_exmem();
    next();
    idex_rs1 = 5'd3; idex_rs2 = 5'd4; exmem_rd = 5'd3; exmem_we = 1;
    #1;
    chk("R1 sel a exmem", fwd_a_sel, 2);
    chk("R1 sel b none", fwd_b_sel, 0);
    chk("R1 no stall", pc_hold, 0);
    exmem_we = 0; idex_rs2 = 5'd3;
    #1;
    chk("R1 we low no fwd", fwd_b_sel, 0);
  endtask

  task automatic t_memwb();
    next();
    idex_rs2 = 5'd5; memwb_rd = 5'd5; memwb_we = 1; exmem_rd = 5'd6; exmem_we = 1;
    #1;
    chk("R2 sel b memwb", fwd_b_sel, 1);
    chk("R2 sel a rf", fwd_a_sel, 0);
  endtask

  task automatic t_priority();
    next();
    idex_rs1 = 5'd7; idex_rs2 = 5'd7;
    exmem_rd = 5'd7; exmem_we = 1; memwb_rd = 5'd7; memwb_we = 1;
    #1;
    chk("R3 sel a younger", fwd_a_sel, 2);
    chk("R3 sel b younger", fwd_b_sel, 2);
  endtask

  task automatic t_zero();
    int base;
    next();
    base = stall_cnt;
    exmem_rd = '0; exmem_we = 1; memwb_rd = '0; memwb_we = 1;
    idex_rd = '0; idex_is_load = 1; id_rs1 = '0; id_rs1_used = 1;
    #1;
    chk("R4 zero sel a", fwd_a_sel, 0);
    chk("R4 zero sel b", fwd_b_sel, 0);
    chk("R4 zero no stall", pc_hold, 0);
    next();
    chk("R4 zero cnt", stall_cnt, base);
  endtask

  task automatic t_loaduse();
    int base;
    next();
    base = stall_cnt;
    idex_rd = 5'd9; idex_is_load = 1; id_rs2 = 5'd9; id_rs2_used = 1;
    #1;
    chk("R5 pc_hold", pc_hold, 1);
    chk("R5 ifid_hold", ifid_hold, 1);
    chk("R5 idex_bubble", idex_bubble, 1);
    next();
    memwb_rd = '0; exmem_rd = 5'd9; exmem_we = 1; exmem_rd = 5'd9;
    id_rs2 = 5'd9; id_rs2_used = 1;
    #1;
    chk("R5 bubble cycle no stall", pc_hold, 0);
    chk("R9 stall_cnt +1", stall_cnt, base + 1);
    next();
    idex_rs2 = 5'd9; memwb_rd = 5'd9; memwb_we = 1;
    #1;
    chk("R5 consumer from memwb", fwd_b_sel, 1);
    chk("R5 no second stall", pc_hold, 0);
    next();
    chk("R9 stall_cnt stays", stall_cnt, base + 1);
  endtask

  task automatic t_nostall();
    next();
    idex_rd = 5'd11; idex_is_load = 0; id_rs1 = 5'd11; id_rs1_used = 1;
    #1;
    chk("R6 alu producer", pc_hold, 0);
    idex_is_load = 1; id_rs1_used = 0; id_rs2 = 5'd11; id_rs2_used = 0;
    #1;
    chk("R6 unused source", idex_bubble, 0);
  endtask

  task automatic t_branch();
    int base;
    next();
    base = flush_cnt;
    branch_taken = 1;
    #1;
    chk("R7 redirect", pc_redirect, 1);
    chk("R7 ifid_flush", ifid_flush, 1);
    chk("R7 idex_flush", idex_flush, 1);
    next();
    #1;
    chk("R7 not taken no flush", ifid_flush + idex_flush + pc_redirect, 0);
    chk("R9 flush_cnt +2", flush_cnt, base + 2);
    next();
    chk("R9 flush_cnt stays", flush_cnt, base + 2);
  endtask

  task automatic t_flush_prio();
    int sbase, fbase;
    next();
    sbase = stall_cnt; fbase = flush_cnt;
    branch_taken = 1; idex_rd = 5'd12; idex_is_load = 1;
    id_rs1 = 5'd12; id_rs1_used = 1;
    #1;
    chk("R8 no pc_hold", pc_hold, 0);
    chk("R8 no bubble", idex_bubble, 0);
    chk("R8 flush", idex_flush, 1);
    next();
    chk("R8 stall_cnt unchanged", stall_cnt, sbase);
    chk("R8 flush_cnt +2", flush_cnt, fbase + 2);
  endtask

  initial begin
    t_reset();
    t_exmem();
    t_memwb();
    t_priority();
    t_zero();
    t_loaduse();
    t_nostall();
    t_branch();
    t_flush_prio();
    next();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  end
endmodule